// File: doc/BRIEF.md
# UART Interrupt Source Controller

This block collects the interrupt conditions of a small UART that is driven by a serial host. It produces four status bits and a single active-low interrupt request. The four sources are:

- receive data waiting;
- transmit buffer empty;
- the parity bit of the next word to be read;
- a shared error/activity bit. In normal operation this bit reports a framing error. In shutdown it reports activity on the RX line.

Each source has its own mask. A source drives the interrupt only while its mask is 1.

The receiver, the transmitter and the receive FIFO report to the block through single-cycle strobes and levels. The block keeps its own copy of the receive FIFO occupancy and of the parity bits, so the parity flag always belongs to the oldest unread word. The host interface sends a one-cycle pulse when a read-data operation ends. That pulse clears a pending transmit-empty interrupt. The transmit-empty status bit stays readable for polling after the clear.

Top module: `uic_irq_ctrl`

## Requirements
- R1: After reset, `st_data`, `st_par` and `st_err` are 0, `irq_n` is 1, and `st_txe` equals `tx_empty`.
- R2: `st_data` is 1 exactly while the tracked receive occupancy is nonzero.
  - A `rx_push` while 8 words are held is dropped, unless a pop happens in the same cycle.
  - A `rx_pop` while the FIFO is empty is ignored.
- R3: `st_par` is 1 only when all three hold: `par_en` is 1, the FIFO holds data, and the parity bit pushed with the oldest unread word (`rx_push_par`) was 1.
- R4: `st_txe` follows `tx_empty` combinationally.
  - A 0-to-1 change of `tx_empty` while `mask_tx` is 1 makes the transmit interrupt pending from the next edge.
  - A `rd_done` pulse clears the pending interrupt. `st_txe` stays 1 afterwards.
- R5: When a transmit-empty rising event and `rd_done` fall in the same cycle, the transmit interrupt stays pending.
- R6: While `shdn` is 0, `st_err` shows the framing flag.
  - `frame_done` with `frame_stop_ok`=0 sets the flag.
  - `frame_done` with `frame_stop_ok`=1 clears it.
  - Without `frame_done` the flag holds.
- R7: While `shdn` is 1, `st_err` shows the RX activity flag.
  - `rx_line` passes through two synchronizer flops. A change of `rx_line` sets the flag on the third clock edge after the change.
  - A change detected on the first edge of shutdown is ignored.
  - The flag clears at the first edge with `shdn`=0, and `st_err` then shows the framing flag again.
- R8: `irq_n` is 0 exactly when at least one of these holds: (`st_data` and `mask_rx`), (transmit pending and `mask_tx`), (`st_par` and `mask_par`), (`st_err` and `mask_err`).
- R9: `rst_n` low resets all state asynchronously, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | A received word enters the receive FIFO |
| rx_push_par | input | 1 | Received parity bit of the word being pushed |
| rx_pop | input | 1 | The oldest word leaves the receive FIFO |
| par_en | input | 1 | Parity checking enabled |
| frame_done | input | 1 | The receiver finished a character |
| frame_stop_ok | input | 1 | First stop bit of that character sampled as 1 |
| tx_empty | input | 1 | The transmit buffer can accept data |
| rd_done | input | 1 | Pulse at the end of a read-data operation |
| shdn | input | 1 | Shutdown mode |
| rx_line | input | 1 | Asynchronous RX line |
| mask_rx | input | 1 | Enable for the data-waiting source |
| mask_tx | input | 1 | Enable for the transmit-empty source |
| mask_par | input | 1 | Enable for the parity source |
| mask_err | input | 1 | Enable for the error/activity source |
| st_data | output | 1 | Receive data waiting |
| st_txe | output | 1 | Transmit buffer empty |
| st_par | output | 1 | Parity bit of the oldest word |
| st_err | output | 1 | Framing error, or RX activity in shutdown |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with the default depth of 8. At that depth an overfilled FIFO, a pop from an empty FIFO, and a wrap of the parity pointers all occur within a few dozen cycles.

A long pseudo-random sweep steps through all 16 mask combinations. It crosses shutdown entry and exit with RX toggling and mixes pushes, pops and read-done pulses. Every output is compared against a cycle model that is derived from the requirements. Directed sequences pin down:

- the synchronizer latency;
- the ignored first shutdown sample;
- the same-cycle transmit event and clear;
- an asynchronous reset in the middle of a run.

// File: rtl/uic_pkg.sv
package uic_pkg;

    parameter int unsigned UIC_DEF_DEPTH = 8;

    typedef struct packed {
        logic data;
        logic txe;
        logic par;
        logic err;
    } uic_src_t;

endpackage

// File: rtl/uic_par_fifo.sv
module uic_par_fifo #(
    parameter int unsigned DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_par,
    input  logic pop,
    input  logic par_en,
    output logic has_data,
    output logic oldest_par
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] bits;
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && ((st_q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.bits[st_q.wr] = push_par;
            st_d.wr            = ptr_next(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign has_data   = (st_q.cnt != '0);
    assign oldest_par = par_en && has_data && st_q.bits[st_q.rd];

endmodule

// File: rtl/uic_rx_activity.sv
module uic_rx_activity (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn,
    input  logic rx_line,
    output logic act
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic armed;
        logic act;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = rx_line;
        st_d.s2    = st_q.s1;
        st_d.prev  = st_q.s2;
        st_d.armed = shdn;
        if (shdn) begin
            st_d.act = st_q.act | (st_q.armed & (st_q.s2 ^ st_q.prev));
        end else begin
            st_d.act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, prev: 1'b1, armed: 1'b0, act: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;

endmodule

// File: rtl/uic_tx_event.sv
module uic_tx_event (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic mask_tx,
    input  logic rd_done,
    output logic rise,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } tx_st_t;

    tx_st_t st_d, st_q;

    assign rise = tx_empty & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tx_empty;
        st_d.pend = (rise & mask_tx) | (st_q.pend & ~rd_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{prev: 1'b1, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/uic_irq_ctrl.sv
module uic_irq_ctrl
    import uic_pkg::*;
#(
    parameter int unsigned DEPTH = UIC_DEF_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_push,
    input  logic rx_push_par,
    input  logic rx_pop,
    input  logic par_en,
    input  logic frame_done,
    input  logic frame_stop_ok,
    input  logic tx_empty,
    input  logic rd_done,
    input  logic shdn,
    input  logic rx_line,
    input  logic mask_rx,
    input  logic mask_tx,
    input  logic mask_par,
    input  logic mask_err,
    output logic st_data,
    output logic st_txe,
    output logic st_par,
    output logic st_err,
    output logic irq_n
);
    typedef struct packed {
        logic fe;
    } top_st_t;

    top_st_t  st_d, st_q;
    uic_src_t src;
    logic     has_data, oldest_par, act_flag, tx_rise, tx_pend;

    uic_par_fifo #(.DEPTH(DEPTH)) i_par_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (rx_push),
        .push_par   (rx_push_par),
        .pop        (rx_pop),
        .par_en     (par_en),
        .has_data   (has_data),
        .oldest_par (oldest_par)
    );

    uic_rx_activity i_rx_activity (
        .clk     (clk),
        .rst_n   (rst_n),
        .shdn    (shdn),
        .rx_line (rx_line),
        .act     (act_flag)
    );

    uic_tx_event i_tx_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_empty (tx_empty),
        .mask_tx  (mask_tx),
        .rd_done  (rd_done),
        .rise     (tx_rise),
        .pend     (tx_pend)
    );

    always_comb begin
        st_d = st_q;
        if (frame_done) begin
            st_d.fe = ~frame_stop_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        src.data = has_data;
        src.txe  = tx_empty;
        src.par  = oldest_par;
        src.err  = shdn ? act_flag : st_q.fe;
    end

    assign st_data = src.data;
    assign st_txe  = src.txe;
    assign st_par  = src.par;
    assign st_err  = src.err;
    assign irq_n   = ~((src.data & mask_rx) | (tx_pend & mask_tx) |
                       (src.par & mask_par) | (src.err & mask_err));

endmodule

// File: rtl/uic_irq_ctrl_chk.sv
module uic_irq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_push,
    input logic par_en,
    input logic frame_done,
    input logic frame_stop_ok,
    input logic rd_done,
    input logic shdn,
    input logic mask_rx,
    input logic mask_tx,
    input logic mask_par,
    input logic mask_err,
    input logic st_data,
    input logic st_par,
    input logic st_err,
    input logic irq_n,
    input logic act_flag,
    input logic tx_rise,
    input logic tx_pend
);
    AST_PUSH_GIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> st_data); // R2
    AST_PAR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st_par |-> st_data); // R3
    AST_PAR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !par_en |-> !st_par); // R3
    AST_TX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !tx_rise) |=> !tx_pend); // R4
    AST_TX_RACE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && tx_rise && mask_tx) |=> tx_pend); // R5
    AST_FRAME_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_stop_ok && !shdn) ##1 !shdn |-> st_err); // R6
    AST_ACT_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn |=> !act_flag); // R7
    AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_rx && !mask_tx && !mask_par && !mask_err) |-> irq_n); // R8
    AST_DATA_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_data && mask_rx) |-> !irq_n); // R8
endmodule

bind uic_irq_ctrl uic_irq_ctrl_chk i_uic_irq_ctrl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_push       (rx_push),
    .par_en        (par_en),
    .frame_done    (frame_done),
    .frame_stop_ok (frame_stop_ok),
    .rd_done       (rd_done),
    .shdn          (shdn),
    .mask_rx       (mask_rx),
    .mask_tx       (mask_tx),
    .mask_par      (mask_par),
    .mask_err      (mask_err),
    .st_data       (st_data),
    .st_par        (st_par),
    .st_err        (st_err),
    .irq_n         (irq_n),
    .act_flag      (act_flag),
    .tx_rise       (tx_rise),
    .tx_pend       (tx_pend)
);

// File: tb/test_uic_irq_ctrl.sv
`timescale 1ns/1ps
module test_uic_irq_ctrl;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_push = 0, rx_push_par = 0, rx_pop = 0, par_en = 0;
    logic frame_done = 0, frame_stop_ok = 0, tx_empty = 0, rd_done = 0;
    logic shdn = 0, rx_line = 1;
    logic mask_rx = 0, mask_tx = 0, mask_par = 0, mask_err = 0;
    logic st_data, st_txe, st_par, st_err, irq_n;

    int total = 0;
    int fails = 0;
    bit done = 0;

    // model state
    bit m_bits [DEPTH];
    int m_wr, m_rd, m_cnt;
    bit m_fe, m_s1, m_s2, m_prev, m_armed, m_act, m_txprev, m_pend;

    always #2 clk = ~clk;

    uic_irq_ctrl #(.DEPTH(DEPTH)) i_uic_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_push_par(rx_push_par),
        .rx_pop(rx_pop), .par_en(par_en), .frame_done(frame_done),
        .frame_stop_ok(frame_stop_ok), .tx_empty(tx_empty), .rd_done(rd_done),
        .shdn(shdn), .rx_line(rx_line), .mask_rx(mask_rx), .mask_tx(mask_tx),
        .mask_par(mask_par), .mask_err(mask_err), .st_data(st_data),
        .st_txe(st_txe), .st_par(st_par), .st_err(st_err), .irq_n(irq_n)
    );

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) m_bits[i] = 0;
        m_wr = 0; m_rd = 0; m_cnt = 0; m_fe = 0;
        m_s1 = 1; m_s2 = 1; m_prev = 1; m_armed = 0; m_act = 0;
        m_txprev = 1; m_pend = 0;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit e_data(); return m_cnt != 0; endfunction
    function automatic bit e_par(); return par_en && e_data() && m_bits[m_rd]; endfunction
    function automatic bit e_err(); return shdn ? m_act : m_fe; endfunction
    function automatic bit e_irq();
        return !((e_data() && mask_rx) || (m_pend && mask_tx) ||
                 (e_par() && mask_par) || (e_err() && mask_err));
    endfunction

    task automatic check_all();
        check("R2 st_data", st_data, e_data());
        check("R3 st_par", st_par, e_par());
        check("R4 st_txe", st_txe, tx_empty);
        check(shdn ? "R7 st_err" : "R6 st_err", st_err, e_err());
        check("R8 irq_n", irq_n, e_irq());
    endtask

    // advance one clock; model predicts post-edge state from current inputs
    task automatic step();
        bit dpop, dpush, rise;
        dpop  = rx_pop && (m_cnt != 0);
        dpush = rx_push && ((m_cnt != DEPTH) || dpop);
        rise  = tx_empty && !m_txprev;
        @(posedge clk);
        if (dpush) begin m_bits[m_wr] = rx_push_par; m_wr = (m_wr + 1) % DEPTH; end
        if (dpop) m_rd = (m_rd + 1) % DEPTH;
        m_cnt = m_cnt + (dpush ? 1 : 0) - (dpop ? 1 : 0);
        if (frame_done) m_fe = !frame_stop_ok;
        m_act = shdn ? (m_act || (m_armed && (m_s2 != m_prev))) : 1'b0;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = rx_line; m_armed = shdn;
        m_pend = (rise && mask_tx) || (m_pend && !rd_done);
        m_txprev = tx_empty;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rx_push = 0; rx_pop = 0; frame_done = 0; rd_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf;
        model_reset();
        #9;
        // R1: reset state
        check("R1 st_data", st_data, 0);
        check("R1 st_par", st_par, 0);
        check("R1 st_err", st_err, 0);
        check("R1 irq_n", irq_n, 1);
        check("R1 st_txe", st_txe, tx_empty);
        @(negedge clk);
        rst_n = 1;
        step();
        check_all();

        // R2/R3: overfill with alternating parity, then drain beyond empty
        par_en = 1; mask_par = 1;
        for (int i = 0; i < DEPTH + 1; i++) begin
            rx_push = 1; rx_push_par = (i % 2 == 0);
            step(); check_all();
        end
        rx_push = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            check("R3 oldest parity", st_par, (i < DEPTH) && (i % 2 == 0));
            check("R2 occupancy", st_data, i < DEPTH);
            rx_pop = 1; step(); check_all();
        end
        rx_pop = 0; mask_par = 0;

        // R4/R5: transmit-empty event and same-cycle clear
        mask_tx = 1; tx_empty = 0; step();
        tx_empty = 1; rd_done = 1; step(); rd_done = 0;
        check("R5 pending kept", irq_n, 0);
        check_all();
        rd_done = 1; step(); rd_done = 0;
        check("R4 cleared by rd_done", irq_n, 1);
        check("R4 polled status", st_txe, 1);
        tx_empty = 0; step(); tx_empty = 1; step();
        check("R4 new event pending", irq_n, 0);
        rd_done = 1; step(); rd_done = 0; mask_tx = 0;

        // R6: framing flag
        mask_err = 1;
        frame_done = 1; frame_stop_ok = 0; step(); frame_done = 0;
        check("R6 framing set", st_err, 1);
        step(); check("R6 framing held", st_err, 1);
        frame_done = 1; frame_stop_ok = 1; step(); frame_done = 0;
        check("R6 framing cleared", st_err, 0);
        frame_done = 1; frame_stop_ok = 0; step(); frame_done = 0;

        // R7: first shutdown sample ignored
        rx_line = 0; step(); step();
        shdn = 1; step();
        check("R7 entry ignored", st_err, 0);
        step(); step(); check("R7 still clear", st_err, 0);
        // R7: synchronizer latency of three edges
        rx_line = 1; step(); step();
        check("R7 not yet", st_err, 0);
        step(); check("R7 activity seen", st_err, 1);
        check("R8 activity irq", irq_n, 0);
        shdn = 0; step();
        check("R7 framing visible again", st_err, 1);
        shdn = 1; step(); check("R7 flag cleared on exit", st_err, 0);
        shdn = 0; step(); check_all();

        // sweep: all mask combos, random traffic
        lf = 32'h1ace_b00c;
        for (int c = 0; c < 8192; c++) begin
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            {mask_err, mask_par, mask_tx, mask_rx} = 4'((c >> 6) & 15);
            rx_push = lf[0]; rx_push_par = lf[1]; rx_pop = lf[2] & lf[3];
            par_en = (c >> 10) % 2 == 0 ? 1'b1 : lf[4];
            frame_done = lf[5] & lf[6] & lf[7]; frame_stop_ok = lf[8];
            if (lf[9] & lf[10] & lf[11]) tx_empty = ~tx_empty;
            rd_done = lf[12] & lf[13] & lf[14];
            shdn = ((c / 300) % 3 == 2);
            if (lf[15] & lf[16] & lf[17]) rx_line = ~rx_line;
            step(); check_all();
        end
        idle_inputs();

        // R9: asynchronous reset mid-run
        rx_push = 1; mask_rx = 1; step(); rx_push = 0;
        check("R9 data before reset", st_data, 1);
        #1 rst_n = 0; #0.5;
        check("R9 async data clear", st_data, 0);
        check("R9 async irq high", irq_n, 1);
        model_reset();
        @(negedge clk); rst_n = 1; step(); check_all();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule